// File: doc/BRIEF.md
# Time-Slotted Bit Switching Grid

This block is a rectangular grid of small processing elements that moves single message bits along fixed routes without addresses or buffers. Each element keeps a table of T slot entries. An entry can launch a bit from the element's own source register, name an outgoing direction (north, east, south, west, or none), and mark that a bit arriving on that slot has reached its destination. A route of L hops that launches on slot s uses slots s to s+L-1, one hop per slot. Because the tables are planned so that no element receives or sends twice in a slot, bits never collide and nothing is queued.

Software fills the slot tables, the per-element neighbour masks and the per-element source bits through a shared write port while the grid is idle. A go pulse then runs one traversal of exactly T slots, one slot per clock. At the end, every element that ended a route shows the bit it received on its delivered output. A sticky error flag records any attempt to send through a link that does not exist.

Top module: `pe_array`

## Requirements
- R1: After reset, busy, done, err, every delivered bit and every delivered flag are 0, every slot entry is cleared (no launch, direction disabled, no end mark) and each element's neighbour mask holds exactly the links that exist at its grid position.
- R2: A go pulse while idle starts a traversal: busy is high for exactly T cycles, one slot per cycle from slot 0 to slot T-1, and done is high for the single cycle after the last slot.
- R3: On slot k, an element whose entry k has its launch bit and direction enable set sends its source bit to the neighbour named by the entry.
- R4: A bit received on slot k by an element whose entry k has no end mark is sent on slot k+1 in the direction of that element's entry k+1; the element is armed for that one slot only, so if entry k+1 has its direction disabled the bit is dropped without an error.
- R5: A bit received on slot k by an element whose entry k has its end mark is written to that element's delivered bit and sets its delivered flag; a later delivery in the same traversal replaces the earlier bit.
- R6: An element can receive a forwarded bit and launch its own source bit in the same slot; the forwarded bit is held apart from the source bit and leaves unchanged on the next slot.
- R7: A send toward a direction whose neighbour-mask bit is clear reaches no element and sets err, which stays set until reset.
- R8: Slot-table, mask and source writes are ignored while busy is high.
- R9: Delivered bits and flags are cleared when a traversal starts and hold their values after done until the next start.
- R10: Directions are encoded north 0, east 1, south 2, west 3; element index is row*COLS+col; north leads to the row below in index, east to the next column; a link carries a bit from one element to its neighbour in the named direction.
- R11: A go pulse while busy is ignored and does not restart or lengthen the traversal.
- R12: A mask write stores the written flags ANDed with the element's existing links; clearing a flag makes that link behave as missing (R7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a traversal when idle |
| cfg_pe | input | PW | Element index for all writes |
| cfg_slot | input | SW | Slot index for slot-table writes |
| slot_we | input | 1 | Slot-table write strobe |
| slot_start | input | 1 | Entry launch bit |
| slot_dir_en | input | 1 | Entry direction enable (0 means none) |
| slot_dir | input | 2 | Entry direction (N 0, E 1, S 2, W 3) |
| slot_end | input | 1 | Entry end mark |
| mask_we | input | 1 | Neighbour-mask write strobe |
| mask_data | input | 4 | Mask flags, bit d for direction d |
| src_we | input | 1 | Source-bit write strobe |
| src_data | input | 1 | Source bit value |
| busy | output | 1 | Traversal running |
| done | output | 1 | One-cycle end-of-traversal pulse |
| err | output | 1 | Sticky missing-link error |
| dlv_bit | output | NPE | Delivered bit per element |
| dlv_hit | output | NPE | Delivered flag per element |

## Verification
The bench loads one set of non-conflicting routes that covers a two-hop relay, an element that receives a relayed bit and launches its own in the same slot, two deliveries to one element in one traversal, a relay whose next entry is empty, and a route that reaches the edge of the grid. A design that sent the source bit instead of the held out-box value would deliver the wrong bit at the relay's end; one that kept the armed state past one slot would deliver at the dead-end element; one that let writes through while busy would lose a delivery on the traversal after the poke. A cleared mask flag and an edge send must both raise err and suppress delivery, and err must survive further clean traversals until reset.

// File: rtl/pe_array_pkg.sv
package pe_array_pkg;

   typedef enum logic [1:0] {
      DIR_N = 2'd0,
      DIR_E = 2'd1,
      DIR_S = 2'd2,
      DIR_W = 2'd3
   } dir_e;

   typedef struct packed {
      logic       launch;
      logic       dir_en;
      logic [1:0] dir;
      logic       fin;
   } slot_t;

endpackage

// File: rtl/pe_slot_table.sv
module pe_slot_table
   import pe_array_pkg::*;
#(
   parameter int T  = 8,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] waddr,
   input  slot_t         wdata,
   input  logic [SW-1:0] raddr,
   output slot_t         rdata
);

   slot_t mem [T];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < T; i++) mem[i] <= '0;
      end else if (we && (int'(waddr) < T)) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/pe_cell.sv
module pe_cell
   import pe_array_pkg::*;
#(
   parameter int T  = 8,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          run,
   input  logic [SW-1:0] slot,
   input  logic [3:0]    geo,
   input  logic          tbl_we,
   input  logic [SW-1:0] tbl_addr,
   input  slot_t         tbl_data,
   input  logic          mask_we,
   input  logic [3:0]    mask_data,
   input  logic          src_we,
   input  logic          src_data,
   input  logic          rx_vld,
   input  logic          rx_bit,
   output logic          tx_vld,
   output logic [1:0]    tx_dir,
   output logic          tx_bit,
   output logic          bad_tx,
   output logic          dlv,
   output logic          hit
);

   slot_t      ent;
   logic [3:0] mask;
   logic       src;
   logic       armed;
   logic       outbox;
   logic       send;

   pe_slot_table #(.T(T), .SW(SW)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_data),
      .raddr (slot),
      .rdata (ent)
   );

   assign send   = run && (ent.launch || armed) && ent.dir_en;
   assign tx_dir = ent.dir;
   assign tx_bit = ent.launch ? src : outbox;
   assign tx_vld = send && mask[ent.dir];
   assign bad_tx = send && !mask[ent.dir];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask   <= geo;
         src    <= 1'b0;
         armed  <= 1'b0;
         outbox <= 1'b0;
         dlv    <= 1'b0;
         hit    <= 1'b0;
      end else begin
         if (mask_we) mask <= mask_data & geo;
         if (src_we)  src  <= src_data;
         if (launch) begin
            armed <= 1'b0;
            dlv   <= 1'b0;
            hit   <= 1'b0;
         end else if (run) begin
            armed <= rx_vld && !ent.fin;
            if (rx_vld) begin
               if (ent.fin) begin
                  dlv <= rx_bit;
                  hit <= 1'b1;
               end else begin
                  outbox <= rx_bit;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pe_array.sv
module pe_array
   import pe_array_pkg::*;
#(
   parameter int COLS = 4,
   parameter int ROWS = 2,
   parameter int T    = 8,
   localparam int NPE = COLS * ROWS,
   localparam int PW  = (NPE > 1) ? $clog2(NPE) : 1,
   localparam int SW  = (T > 1) ? $clog2(T) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [PW-1:0]  cfg_pe,
   input  logic [SW-1:0]  cfg_slot,
   input  logic           slot_we,
   input  logic           slot_start,
   input  logic           slot_dir_en,
   input  logic [1:0]     slot_dir,
   input  logic           slot_end,
   input  logic           mask_we,
   input  logic [3:0]     mask_data,
   input  logic           src_we,
   input  logic           src_data,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic [NPE-1:0] dlv_bit,
   output logic [NPE-1:0] dlv_hit
);

   if (T < 2) begin : g_bad_t
      $error("pe_array: T must be at least 2");
   end
   if (NPE < 2) begin : g_bad_n
      $error("pe_array: grid must hold at least 2 elements");
   end

   logic [SW-1:0]  slot;
   logic           launch;
   logic           last;
   logic [NPE-1:0] tx_vld;
   logic [1:0]     tx_dir [NPE];
   logic [NPE-1:0] tx_bit;
   logic [NPE-1:0] bad_tx;
   slot_t          wentry;

   assign launch = go && !busy;
   assign last   = (int'(slot) == T - 1);
   assign wentry = '{launch: slot_start, dir_en: slot_dir_en, dir: slot_dir, fin: slot_end};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         slot <= '0;
         err  <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= err | (|bad_tx);
         if (launch) begin
            busy <= 1'b1;
            slot <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               slot <= '0;
            end else begin
               slot <= slot + 1'b1;
            end
         end
      end
   end

   for (genvar p = 0; p < NPE; p++) begin : g_pe
      localparam int R = p / COLS;
      localparam int C = p % COLS;
      localparam logic [3:0] GEO = {(C > 0), (R < ROWS - 1), (C < COLS - 1), (R > 0)};

      logic [3:0] cv;
      logic [3:0] cb;
      logic       sel;

      assign sel = (int'(cfg_pe) == p) && !busy;

      if (R > 0) begin : g_from_n
         assign cv[0] = tx_vld[p-COLS] && (tx_dir[p-COLS] == 2'(DIR_S));
         assign cb[0] = tx_bit[p-COLS];
      end else begin : g_edge_n
         assign cv[0] = 1'b0;
         assign cb[0] = 1'b0;
      end
      if (C < COLS - 1) begin : g_from_e
         assign cv[1] = tx_vld[p+1] && (tx_dir[p+1] == 2'(DIR_W));
         assign cb[1] = tx_bit[p+1];
      end else begin : g_edge_e
         assign cv[1] = 1'b0;
         assign cb[1] = 1'b0;
      end
      if (R < ROWS - 1) begin : g_from_s
         assign cv[2] = tx_vld[p+COLS] && (tx_dir[p+COLS] == 2'(DIR_N));
         assign cb[2] = tx_bit[p+COLS];
      end else begin : g_edge_s
         assign cv[2] = 1'b0;
         assign cb[2] = 1'b0;
      end
      if (C > 0) begin : g_from_w
         assign cv[3] = tx_vld[p-1] && (tx_dir[p-1] == 2'(DIR_E));
         assign cb[3] = tx_bit[p-1];
      end else begin : g_edge_w
         assign cv[3] = 1'b0;
         assign cb[3] = 1'b0;
      end

      pe_cell #(.T(T), .SW(SW)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .launch    (launch),
         .run       (busy),
         .slot      (slot),
         .geo       (GEO),
         .tbl_we    (slot_we && sel),
         .tbl_addr  (cfg_slot),
         .tbl_data  (wentry),
         .mask_we   (mask_we && sel),
         .mask_data (mask_data),
         .src_we    (src_we && sel),
         .src_data  (src_data),
         .rx_vld    (|cv),
         .rx_bit    (|(cv & cb)),
         .tx_vld    (tx_vld[p]),
         .tx_dir    (tx_dir[p]),
         .tx_bit    (tx_bit[p]),
         .bad_tx    (bad_tx[p]),
         .dlv       (dlv_bit[p]),
         .hit       (dlv_hit[p])
      );
   end

endmodule

// File: rtl/pe_array_chk.sv
module pe_array_chk #(
   parameter int COLS = 4,
   parameter int ROWS = 2,
   parameter int T    = 8,
   localparam int NPE = COLS * ROWS,
   localparam int CW  = $clog2(T + 1) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           go,
   input logic           busy,
   input logic           done,
   input logic           err,
   input logic [NPE-1:0] dlv_bit,
   input logic [NPE-1:0] dlv_hit
);

   logic [CW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)          run_len <= '0;
      else if (go && !busy) run_len <= '0;
      else if (busy)        run_len <= run_len + 1'b1;
   end

   assert_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == CW'(T)));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> busy);

   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go && !done) |=> (run_len != '0));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go) |=> ($stable(dlv_hit) && $stable(dlv_bit)));

endmodule

bind pe_array pe_array_chk #(.COLS(COLS), .ROWS(ROWS), .T(T)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .go      (go),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .dlv_bit (dlv_bit),
   .dlv_hit (dlv_hit)
);

// File: tb/tb_pe_array.sv
`timescale 1ns/1ps
module tb_pe_array;
   localparam int COLS = 4;
   localparam int ROWS = 2;
   localparam int T    = 8;
   localparam int NPE  = COLS * ROWS;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           go = 1'b0;
   logic [2:0]     cfg_pe = '0;
   logic [2:0]     cfg_slot = '0;
   logic           slot_we = 1'b0, slot_start = 1'b0, slot_dir_en = 1'b0, slot_end = 1'b0;
   logic [1:0]     slot_dir = '0;
   logic           mask_we = 1'b0;
   logic [3:0]     mask_data = '0;
   logic           src_we = 1'b0, src_data = 1'b0;
   logic           busy, done, err;
   logic [NPE-1:0] dlv_bit, dlv_hit;

   pe_array #(.COLS(COLS), .ROWS(ROWS), .T(T)) dut (.*);

   always #2.5 clk = ~clk;

   typedef struct {
      logic [7:0] hit;
      logic [7:0] bits;
      logic       err;
      string      tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   int blen  = 0;
   bit ended = 0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: busy length and scoreboard compare at each done
   always @(negedge clk) begin
      if (!rst_n) blen = 0;
      else begin
         if (busy) blen++;
         if (done) begin
            check("R2 busy cycles", blen, T);
            blen = 0;
            if (q.size() == 0) check("R2 unexpected done", 1, 0);
            else begin
               exp_t e;
               e = q.pop_front();
               check({e.tag, " hit"}, dlv_hit, e.hit);
               check({e.tag, " bit"}, dlv_bit, e.bits);
               check({e.tag, " err"}, err, e.err);
            end
         end
      end
   end

   task automatic wr_slot(int pe, int s, bit st, bit de, int d, bit fin);
      cfg_pe = 3'(pe); cfg_slot = 3'(s);
      slot_start = st; slot_dir_en = de; slot_dir = 2'(d); slot_end = fin;
      slot_we = 1'b1;
      @(negedge clk);
      slot_we = 1'b0;
   endtask

   task automatic wr_src(int pe, bit v);
      cfg_pe = 3'(pe); src_data = v; src_we = 1'b1;
      @(negedge clk);
      src_we = 1'b0;
   endtask

   task automatic wr_mask(int pe, logic [3:0] m);
      cfg_pe = 3'(pe); mask_data = m; mask_we = 1'b1;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
      check("R2 done one cycle", done, 0);
   endtask

   task automatic run(logic [7:0] h, logic [7:0] b, logic e, string tag);
      exp_t x;
      x.hit = h; x.bits = b; x.err = e; x.tag = tag;
      q.push_back(x);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      wait_done();
   endtask

   // direction codes N0 E1 S2 W3 (R10)
   task automatic load_routes();
      wr_slot(0, 0, 1, 1, 1, 0);  // p0 launches east on slot 0
      wr_slot(1, 1, 0, 1, 1, 0);  // p1 relays east on slot 1
      wr_slot(2, 1, 0, 0, 0, 1);  // p2 ends on slot 1
      wr_slot(5, 2, 1, 1, 0, 0);  // p5 launches north on slot 2
      wr_slot(1, 2, 0, 0, 0, 1);
      wr_slot(7, 2, 1, 1, 3, 0);  // p7 launches west on slot 2
      wr_slot(6, 2, 0, 0, 0, 1);
      wr_slot(4, 4, 1, 1, 1, 0);  // p4 east into p5 on slot 4
      wr_slot(5, 4, 1, 1, 0, 0);  // p5 launches north while receiving
      wr_slot(1, 4, 0, 0, 0, 1);
      wr_slot(5, 5, 0, 1, 1, 0);  // p5 relays p4 bit east on slot 5
      wr_slot(6, 5, 0, 0, 0, 1);
      wr_slot(3, 6, 1, 1, 2, 0);  // p3 south to p7, p7 slot 7 empty
   endtask

   task automatic reset_check();
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 err", err, 0);
      check("R1 hit", dlv_hit, 0);
      check("R1 bit", dlv_bit, 0);
   endtask

   initial begin
      #(5.0 * 20000);
      check("watchdog", 0, 1);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      reset_check();
      rst_n = 1'b1;
      @(negedge clk);

      load_routes();
      wr_src(0, 1); wr_src(5, 1); wr_src(7, 1); wr_src(4, 0);
      run(8'h46, 8'h06, 1'b0, "R3 R4 R5 R6 R10");

      wr_src(0, 0); wr_src(5, 0); wr_src(4, 1);
      run(8'h46, 8'h40, 1'b0, "R5 R6 R9");

      // poke during busy: slot, source and go must all be ignored
      begin
         exp_t x;
         x.hit = 8'h46; x.bits = 8'h40; x.err = 1'b0; x.tag = "R8 R11 poke";
         q.push_back(x);
         go = 1'b1;
         @(negedge clk);
         go = 1'b0;
         @(negedge clk);
         @(negedge clk);
         cfg_pe = 3'd2; cfg_slot = 3'd1; slot_start = 0; slot_dir_en = 0; slot_end = 0;
         slot_we = 1'b1; go = 1'b1;
         @(negedge clk);
         slot_we = 1'b0; go = 1'b0;
         cfg_pe = 3'd4; src_data = 1'b0; src_we = 1'b1;
         @(negedge clk);
         src_we = 1'b0;
         wait_done();
      end
      run(8'h46, 8'h40, 1'b0, "R8 after poke");

      repeat (3) @(negedge clk);
      check("R9 hit held", dlv_hit, 8'h46);
      check("R9 bit held", dlv_bit, 8'h40);

      wr_mask(0, 4'b1111);         // p0 links E,S only; masked to geometry
      run(8'h46, 8'h40, 1'b0, "R12 and-geometry");
      wr_mask(0, 4'b0100);         // drop east link of p0
      run(8'h42, 8'h40, 1'b1, "R12 masked link");

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      reset_check();
      rst_n = 1'b1;
      @(negedge clk);
      run(8'h00, 8'h00, 1'b0, "R1 tables cleared");

      load_routes();
      wr_src(0, 1); wr_src(5, 1); wr_src(4, 0);
      run(8'h46, 8'h06, 1'b0, "R1 mask restored");

      wr_slot(3, 3, 1, 1, 1, 0);   // p3 east off the grid edge
      run(8'h46, 8'h06, 1'b1, "R7 edge send");
      run(8'h46, 8'h06, 1'b1, "R7 sticky");

      check("R2 queue drained", q.size(), 0);
      finish_up();
   end
endmodule